// File: doc/BRIEF.md
# Self-Calibrating Manchester Bit-Period Tracker and Decoder

The block receives a Manchester-coded serial line that is sampled on the system clock alone. There is no companion data clock. It counts the clock cycles between successive line transitions and gathers these counts into batches of 1024 transitions. For each batch it builds an 11-bit occupancy mask: bit k is set when an interval of k+1 cycles was seen at least once during the batch. At the end of the batch it looks for a run of empty mask positions that has occupied positions on both sides. The cycle count at the lowest empty position of that run becomes the threshold that separates half-bit intervals from full-bit intervals. Calibration then restarts with no further action.

A small decoder uses the current threshold to recover the data bits. For software it exposes the last mask, the threshold, a flag that shows whether the latest calibration failed, and a sticky failure flag that is cleared by a read strobe. The clock must run at least six times faster than the Manchester bit rate.

Top module: `mcal_top`

## Requirements
- R1: An interval is the number of clock cycles between two consecutive transitions of `line_i`. The first transition after reset only starts the measurement and is not counted.
- R2: Every 1024 counted transitions close a batch. `cal_done_o` then pulses for one cycle, and the mask, threshold and flags update in that same cycle.
- R3: Bit k of `mask_o` (k = 0..10) is 1 exactly when an interval of k+1 cycles occurred in the batch just closed. An example is a batch of 3, 4, 7 and 8 cycle intervals, which gives 0x0CC.
- R4: Intervals of 12 cycles or more saturate. They set no mask bit but still count toward the batch size.
- R5: A batch passes when some zero bit of the mask has a one at a lower index and a one at a higher index. `thr_o` then becomes one plus the index of the lowest such zero. The 0x0CC example gives 5; a mask with only bits 0 and 10 set gives 2.
- R6: A batch with no such zero fails. On failure `last_fail_o` goes to 1 and `thr_o` keeps its previous value. `thr_o` is 0 until the first passing batch.
- R7: `last_fail_o` reflects only the most recent batch; a passing batch returns it to 0.
- R8: `any_fail_o` is set by any failing batch and cleared by a one-cycle pulse on `stat_rd_i`. When a failure and a read fall in the same cycle, the failure wins.
- R9: An interval below `thr_o` is a half bit; an interval at or above it is a full bit. Each mid-bit transition produces one `bit_vld_o` pulse, and `bit_o` equals the line level after that transition (a rising mid-bit transition means 1).
- R10: The decoder emits nothing while `thr_o` is 0, and it drops synchronisation after a saturated interval. It regains synchronisation on the next full-bit interval, which always ends on a mid-bit transition.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Manchester-coded serial line |
| stat_rd_i | input | 1 | Read strobe that clears the sticky failure flag |
| mask_o | output | MASK_W | Occupancy mask of the last closed batch |
| thr_o | output | LEN_W | Half/full interval threshold in cycles, 0 = none yet |
| last_fail_o | output | 1 | Most recent batch failed |
| any_fail_o | output | 1 | Sticky: some batch failed since the last read |
| cal_done_o | output | 1 | One-cycle pulse when a batch closes |
| bit_o | output | 1 | Recovered data bit |
| bit_vld_o | output | 1 | Strobe qualifying `bit_o` |

## Verification
The assertions assume two things: `line_i` changes only between clock edges, and `stat_rd_i` is a single-cycle pulse. They also assume that a threshold exists only when a batch has passed, so any decoder output presumes a nonzero threshold and a preceding transition event. The stimulus changes the line only on the falling clock edge, and every interval it produces is known in advance, so the bench can predict each batch's mask and threshold exactly. Read strobes are issued only while the line is idle and far from a batch boundary. Decoded data is sent at a half-bit length of three cycles, which keeps the clock-to-bit-rate ratio at six.

// File: rtl/mcal_pkg.sv
package mcal_pkg;
  // Decoder phase: hunting for a full-bit interval, last edge mid-bit,
  // or last edge on a bit boundary.
  typedef enum logic [1:0] {
    DS_HUNT = 2'd0,
    DS_MID  = 2'd1,
    DS_BND  = 2'd2
  } dec_state_e;
endpackage

// File: rtl/mcal_interval.sv
module mcal_interval #(
  parameter int SAT   = 12,
  parameter int LEN_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  output logic             ev_o,
  output logic [LEN_W-1:0] len_o,
  output logic             lvl_o
);
  logic             s1, s2, primed;
  logic [LEN_W-1:0] cnt;
  logic             edge_w;

  assign edge_w = s1 ^ s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      primed <= 1'b0;
      cnt    <= LEN_W'(SAT);
      ev_o   <= 1'b0;
      len_o  <= '0;
      lvl_o  <= 1'b0;
    end else begin
      s1    <= line_i;
      s2    <= s1;
      ev_o  <= edge_w & primed;
      lvl_o <= s1;
      if (edge_w) begin
        primed <= 1'b1;
        len_o  <= cnt;
        cnt    <= LEN_W'(1);
      end else if (cnt != LEN_W'(SAT)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    ev_o |-> (len_o >= LEN_W'(1)) && (len_o <= LEN_W'(SAT)));
endmodule

// File: rtl/mcal_hist.sv
module mcal_hist #(
  parameter int MASK_W = 11,
  parameter int BATCH  = 1024,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              stat_rd_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [LEN_W-1:0]  thr_o,
  output logic              last_fail_o,
  output logic              any_fail_o,
  output logic              done_o
);
  localparam int BC_W = $clog2(BATCH);

  logic [MASK_W-1:0] acc, hit, fin, lo_seen, hi_seen;
  logic [BC_W-1:0]   bcnt;
  logic              batch_end, found, lo_run, hi_run;
  logic [LEN_W-1:0]  gap_thr;

  always_comb begin
    hit = '0;
    for (int i = 0; i < MASK_W; i++)
      if (len_i == LEN_W'(i + 1)) hit[i] = 1'b1;
  end

  assign batch_end = ev_i && (bcnt == BC_W'(BATCH - 1));
  assign fin       = acc | (ev_i ? hit : '0);

  // Gap search: lowest empty slot with occupied slots below and above.
  always_comb begin
    lo_run = 1'b0;
    for (int i = 0; i < MASK_W; i++) begin
      lo_seen[i] = lo_run;
      lo_run     = lo_run | fin[i];
    end
    hi_run = 1'b0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      hi_seen[i] = hi_run;
      hi_run     = hi_run | fin[i];
    end
    found   = 1'b0;
    gap_thr = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (!found && !fin[i] && lo_seen[i] && hi_seen[i]) begin
        found   = 1'b1;
        gap_thr = LEN_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      bcnt        <= '0;
      mask_o      <= '0;
      thr_o       <= '0;
      last_fail_o <= 1'b0;
      any_fail_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o     <= batch_end;
      any_fail_o <= (any_fail_o & ~stat_rd_i) | (batch_end & ~found);
      if (ev_i) begin
        if (batch_end) begin
          acc  <= '0;
          bcnt <= '0;
        end else begin
          acc  <= fin;
          bcnt <= bcnt + 1'b1;
        end
      end
      if (batch_end) begin
        mask_o      <= fin;
        last_fail_o <= ~found;
        if (found) thr_o <= gap_thr;
      end
    end
  end

  // R2
  thr_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(thr_o) |-> $past(batch_end));
  // R6
  fail_keeps_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && last_fail_o) |-> $stable(thr_o));
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && last_fail_o) |-> any_fail_o);
  // R5
  pass_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !last_fail_o) |-> (thr_o >= LEN_W'(2)) && !mask_o[thr_o - 1'b1]);
endmodule

// File: rtl/mcal_decoder.sv
module mcal_decoder
  import mcal_pkg::*;
#(
  parameter int SAT   = 12,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             lvl_i,
  input  logic [LEN_W-1:0] thr_i,
  output logic             bit_o,
  output logic             vld_o
);
  dec_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= DS_HUNT;
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (ev_i) begin
        if (thr_i == '0 || len_i == LEN_W'(SAT)) begin
          st <= DS_HUNT;
        end else if (len_i >= thr_i) begin
          st    <= DS_MID;
          vld_o <= 1'b1;
          bit_o <= lvl_i;
        end else if (st == DS_MID) begin
          st <= DS_BND;
        end else if (st == DS_BND) begin
          st    <= DS_MID;
          vld_o <= 1'b1;
          bit_o <= lvl_i;
        end
      end
    end
  end

  // R10
  no_thr_no_bit_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ($past(ev_i) && $past(thr_i) != '0));
  // R10
  sat_no_bit_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ($past(len_i) != LEN_W'(SAT)));
  // R9
  bit_level_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (bit_o == $past(lvl_i)));
endmodule

// File: rtl/mcal_top.sv
module mcal_top #(
  parameter int MASK_W = 11,
  parameter int BATCH  = 1024,
  localparam int SAT   = MASK_W + 1,
  localparam int LEN_W = $clog2(SAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic              stat_rd_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [LEN_W-1:0]  thr_o,
  output logic              last_fail_o,
  output logic              any_fail_o,
  output logic              cal_done_o,
  output logic              bit_o,
  output logic              bit_vld_o
);
  logic             ev;
  logic [LEN_W-1:0] len;
  logic             lvl;

  mcal_interval #(.SAT(SAT), .LEN_W(LEN_W)) u_int (
    .clk(clk), .rst(rst), .line_i(line_i),
    .ev_o(ev), .len_o(len), .lvl_o(lvl)
  );

  mcal_hist #(.MASK_W(MASK_W), .BATCH(BATCH), .LEN_W(LEN_W)) u_hist (
    .clk(clk), .rst(rst), .ev_i(ev), .len_i(len), .stat_rd_i(stat_rd_i),
    .mask_o(mask_o), .thr_o(thr_o), .last_fail_o(last_fail_o),
    .any_fail_o(any_fail_o), .done_o(cal_done_o)
  );

  mcal_decoder #(.SAT(SAT), .LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst(rst), .ev_i(ev), .len_i(len), .lvl_i(lvl),
    .thr_i(thr_o), .bit_o(bit_o), .vld_o(bit_vld_o)
  );
endmodule

// File: tb/sim_mcal_top.sv
module sim_mcal_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [10:0] mask;
    logic [3:0]  thr;
    logic        lf;
    logic        af;
  } cal_t;

  logic        clk = 1'b0, rst = 1'b1, line = 1'b0, stat_rd = 1'b0;
  logic [10:0] mask;
  logic [3:0]  thr;
  logic        lf, af, done, bit_d, bit_v;

  int checks = 0, errors = 0;
  cal_t cq[$];
  logic bq[$];
  logic chk_bits = 1'b0;

  // bench model of batches
  logic        primed = 1'b0;
  logic [10:0] m_acc = '0;
  int          m_cnt = 0;
  logic [3:0]  m_thr = '0;
  logic        m_any = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcal_top u0 (
    .clk(clk), .rst(rst), .line_i(line), .stat_rd_i(stat_rd),
    .mask_o(mask), .thr_o(thr), .last_fail_o(lf), .any_fail_o(af),
    .cal_done_o(done), .bit_o(bit_d), .bit_vld_o(bit_v)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gap_of(input logic [10:0] m);
    for (int i = 1; i < 10; i++)
      if (!m[i] && (m & ((11'd1 << i) - 11'd1)) != 0 && (m >> (i + 1)) != 0)
        return i + 1;
    return 0;
  endfunction

  task automatic close_batch();
    cal_t e;
    int   g;
    g      = gap_of(m_acc);
    e.mask = m_acc;
    e.lf   = (g == 0);
    if (g != 0) m_thr = 4'(g);
    e.thr  = m_thr;
    m_any  = m_any | e.lf;
    e.af   = m_any;
    cq.push_back(e);
    m_acc  = '0;
    m_cnt  = 0;
  endtask

  // Driver: wait k cycles since the previous toggle, then toggle the line.
  task automatic toggle_after(input int k);
    repeat (k) @(negedge clk);
    line = ~line;
    if (!primed) primed = 1'b1;
    else begin
      if (k <= 11) m_acc[k-1] = 1'b1;
      m_cnt++;
      if (m_cnt == 1024) close_batch();
    end
  endtask

  task automatic send_data(input int n, input int h);
    logic b[64];
    int   pend, j;
    logic lv;
    for (int i = 0; i < n; i++) b[i] = 1'($urandom);
    b[1] = ~b[0];
    j = 1;
    for (int i = j; i < n; i++) bq.push_back(b[i]);
    pend = 20;
    for (int i = 0; i < n; i++)
      for (int hh = 0; hh < 2; hh++) begin
        lv = (hh == 0) ? ~b[i] : b[i];
        if (lv != line) begin
          toggle_after(pend);
          pend = h;
        end else pend += h;
      end
    repeat (pend) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (cq.size() == 0) check(1'b0, "R2 unexpected cal_done", 1, 0);
      else begin
        cal_t e;
        e = cq.pop_front();
        check(mask == e.mask, "R3 mask", int'(mask), int'(e.mask));
        check(thr == e.thr, "R5/R6 threshold", int'(thr), int'(e.thr));
        check(lf == e.lf, "R6/R7 last_fail", int'(lf), int'(e.lf));
        check(af == e.af, "R8 any_fail", int'(af), int'(e.af));
      end
    end
    if (!rst && bit_v) begin
      if (thr == 0) check(1'b0, "R10 bit without threshold", 1, 0);
      if (chk_bits) begin
        if (bq.size() == 0) check(1'b0, "R10 extra decoded bit", int'(bit_d), -1);
        else begin
          logic eb;
          eb = bq.pop_front();
          check(bit_d == eb, "R9 decoded bit", int'(bit_d), int'(eb));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(mask == 0, "R11 mask", int'(mask), 0);
    check(thr == 0, "R11/R6 threshold", int'(thr), 0);
    check(lf == 0, "R11 last_fail", int'(lf), 0);
    check(af == 0, "R11 any_fail", int'(af), 0);
    check(done == 0, "R11 cal_done", int'(done), 0);
    check(bit_v == 0, "R11 bit_vld", int'(bit_v), 0);

    toggle_after(5);  // R1 priming transition
    // Batch A: 3,4,7,8 -> mask 0x0CC, thr 5 (R3, R5)
    for (int i = 0; i < 256; i++) begin
      toggle_after(3); toggle_after(4); toggle_after(7); toggle_after(8);
    end
    // Batch B: only 4 -> fail, thr kept (R6, R8)
    for (int i = 0; i < 1024; i++) toggle_after(4);
    repeat (20) @(negedge clk);
    check(lf == 1, "R6 last_fail after fail", int'(lf), 1);
    check(af == 1, "R8 any_fail set", int'(af), 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    m_any   = 1'b0;
    @(negedge clk);
    check(af == 0, "R8 any_fail cleared by read", int'(af), 0);
    check(lf == 1, "R7 last_fail unaffected by read", int'(lf), 1);
    // Batch D: 1 and 11 -> thr 2, passes (R5, R7)
    for (int i = 0; i < 512; i++) begin
      toggle_after(1); toggle_after(11);
    end
    // Batch E: all saturated -> mask 0, fail (R4, R6)
    for (int i = 0; i < 1024; i++) toggle_after(14);
    // Batch C: 3/6 with one saturated interval -> mask bits 2,5, thr 4 (R4, R5)
    for (int i = 0; i < 1023; i++) toggle_after((i % 2 == 0) ? 3 : 6);
    toggle_after(20);
    repeat (30) @(negedge clk);
    check(cq.size() == 0, "R2 all batches reported", cq.size(), 0);
    check(thr == 4, "R5 threshold before data", int'(thr), 4);

    // Decoding at half-bit 3 cycles (R9, R10)
    chk_bits = 1'b1;
    send_data(60, 3);
    repeat (40) @(negedge clk);
    check(bq.size() == 0, "R9 all bits decoded", bq.size(), 0);
    chk_bits = 1'b0;
    check(cq.size() == 0, "R2 no spurious batch", cq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule